// File: doc/BRIEF.md
# Skewed-Associative Cache Tag Lookup

This block holds the tags of one bank of a skewed-associative cache and performs the lookup for it. Unlike a set-associative tag array, where every way is read at a single shared set index, each way here computes its own set index from the block address with a per-way hash. A request is looked up in all ways at once. One cycle later the block reports whether the address hit, and in which way.

On every response the block also presents one replacement candidate per way: the valid bit, dirty bit, stored tag and set index that this way holds for the requested address. On a miss these candidates come from different sets, and an external replacement selector picks a victim among them. The selector then issues a fill naming the chosen way. The fill writes the new tag, a valid bit and the dirty flag into that way only, at the index that way computes for the fill address.

The hash is chosen by a parameter. The default is an odd-multiplier displacement hash, made from one shift and two adds. The alternative is a rotate-and-XOR hash. Addresses enter as line addresses: the byte address with the block offset (128-byte blocks by default) and the bank-select bits already removed.

Top module: `skc_lookup`

## Requirements
- R1: In a line address, bits [SET_W-1:0] form field A1 and bits [2*SET_W-1:SET_W] form field A2. The stored tag is the whole line address, including A1 and A2. Two lines that land on the same index of a way but differ in A1 or A2 therefore never match each other.
- R2: In displacement mode, way w uses the index ((A2 << w) + A2 + A1) mod 2^SET_W.
- R3: In displacement mode, a way whose number w is at least SET_W uses the index (A2 + A1) mod 2^SET_W, because the shifted term drops out. All such ways share one index.
- R4: In XOR mode, way w uses the index rotl(A2, w mod SET_W) XOR A1, where rotl rotates toward the most significant bit. Ways whose numbers are congruent mod SET_W therefore share an index.
- R5: resp_valid is high in exactly the cycles that follow a cycle with req_valid high.
- R6: resp_hit_way bit w is set when way w holds a valid entry at its own index whose stored tag equals the requested line. resp_hit is the OR of these bits. The vector is one-hot or zero, provided the caller never fills a line that is already present.
- R7: With every response, for each way w, cand_valid[w], cand_dirty[w], cand_tag slice w and cand_idx slice w give that way's entry at the index it computed for the request. A tag slice is meaningful only while its valid bit is set.
- R8: A fill with fill_way = k writes tag = fill_line, valid = 1 and dirty = fill_dirty into way k only, at the index way k computes for fill_line. Other ways and other sets keep their contents. A cycle without a fill changes no valid or dirty bit.
- R9: Reset clears every valid and dirty bit and drops resp_valid. Lookups after reset miss, and every candidate is reported invalid.
- R10: A lookup issued in the same cycle as a fill sees the contents from before that fill. The fill is visible to lookups issued in later cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_line | input | LINE_W | Line address to look up |
| fill_valid | input | 1 | Fill strobe |
| fill_line | input | LINE_W | Line address to install |
| fill_way | input | WAY_W | Way chosen by the replacement selector |
| fill_dirty | input | 1 | Dirty flag stored with the fill |
| resp_valid | output | 1 | Lookup result valid |
| resp_hit | output | 1 | Any way hit |
| resp_hit_way | output | WAYS | One-hot hit way |
| cand_valid | output | WAYS | Per-way candidate valid bit |
| cand_dirty | output | WAYS | Per-way candidate dirty bit |
| cand_tag | output | WAYS*LINE_W | Per-way candidate stored tag, way w at slice w |
| cand_idx | output | WAYS*SET_W | Per-way set index used, way w at slice w |

## Verification
The bench builds two copies of the block, each with SET_W = 4 (16 sets) and eight ways: one in displacement mode, one in XOR mode. Eight ways over a 4-bit index make ways 4 to 7 collapse onto a single displacement index, and make the XOR rotation wrap so that way 4 repeats way 0. The small set count also forces frequent index collisions and evictions while a short pool of lines is driven through both copies. A directed pair of lines that share a way-0 index exercises the full-width tag compare.

// File: rtl/skc_pkg.sv
package skc_pkg;
  typedef enum logic [0:0] {
    HASH_ODISP = 1'b0,
    HASH_XOR   = 1'b1
  } hash_e;
endpackage

// File: rtl/skc_hash.sv
module skc_hash #(
  parameter int SET_W = 6,
  parameter int WAY = 0,
  parameter skc_pkg::hash_e MODE = skc_pkg::HASH_ODISP
) (
  input  logic [SET_W-1:0] a1,
  input  logic [SET_W-1:0] a2,
  output logic [SET_W-1:0] idx
);
  generate
    if (MODE == skc_pkg::HASH_XOR) begin : g_xor
      localparam int ROT = WAY % SET_W;
      if (ROT == 0) begin : g_norot
        assign idx = a2 ^ a1;
      end else begin : g_rot
        assign idx = {a2[SET_W-1-ROT:0], a2[SET_W-1:SET_W-ROT]} ^ a1;
      end
    end else begin : g_odisp
      if (WAY >= SET_W) begin : g_noshift
        // shifted term lies wholly above the index width
        assign idx = a2 + a1;
      end else begin : g_shift
        assign idx = (a2 << WAY) + a2 + a1;
      end
    end
  endgenerate
endmodule

// File: rtl/skc_way_store.sv
module skc_way_store #(
  parameter int SET_W = 6,
  parameter int TAG_W = 23,
  localparam int NSET = 1 << SET_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] raddr,
  input  logic             we,
  input  logic [SET_W-1:0] waddr,
  input  logic [TAG_W-1:0] wtag,
  input  logic             wdirty,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_vld,
  output logic             rd_drt
);
  logic [TAG_W-1:0] mem [NSET];
  logic [NSET-1:0]  vld;
  logic [NSET-1:0]  drt;

  // tag array: plain synchronous RAM, read-first
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wtag;
    rd_tag <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld    <= '0;
      drt    <= '0;
      rd_vld <= 1'b0;
      rd_drt <= 1'b0;
    end else begin
      if (we) begin
        vld[waddr] <= 1'b1;
        drt[waddr] <= wdirty;
      end
      rd_vld <= vld[raddr];
      rd_drt <= drt[raddr];
    end
  end

  p_fill_sets_valid_r8: assert property (@(posedge clk) disable iff (rst)
    we |=> vld[$past(waddr)]);
  p_idle_keeps_state_r8: assert property (@(posedge clk) disable iff (rst)
    !we |=> ($stable(vld) && $stable(drt)));
endmodule

// File: rtl/skc_lookup.sv
module skc_lookup #(
  parameter int ADDR_W = 32,
  parameter int BLK_BYTES = 128,
  parameter int BANKS = 4,
  parameter int SET_W = 6,
  parameter int WAYS = 4,
  parameter skc_pkg::hash_e HASH = skc_pkg::HASH_ODISP,
  localparam int BLK_OFF = $clog2(BLK_BYTES),
  localparam int BANK_W = $clog2(BANKS),
  localparam int LINE_W = ADDR_W - BLK_OFF - BANK_W,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [LINE_W-1:0]       req_line,
  input  logic                    fill_valid,
  input  logic [LINE_W-1:0]       fill_line,
  input  logic [WAY_W-1:0]        fill_way,
  input  logic                    fill_dirty,
  output logic                    resp_valid,
  output logic                    resp_hit,
  output logic [WAYS-1:0]         resp_hit_way,
  output logic [WAYS-1:0]         cand_valid,
  output logic [WAYS-1:0]         cand_dirty,
  output logic [WAYS*LINE_W-1:0]  cand_tag,
  output logic [WAYS*SET_W-1:0]   cand_idx
);
  logic [SET_W-1:0]  req_a1, req_a2, fil_a1, fil_a2;
  logic [LINE_W-1:0] tag_q;
  logic              vld_q;

  assign req_a1 = req_line[SET_W-1:0];
  assign req_a2 = req_line[2*SET_W-1:SET_W];
  assign fil_a1 = fill_line[SET_W-1:0];
  assign fil_a2 = fill_line[2*SET_W-1:SET_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      tag_q <= '0;
    end else begin
      vld_q <= req_valid;
      if (req_valid) tag_q <= req_line;
    end
  end

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [SET_W-1:0]  ridx, widx, ridx_q;
      logic [LINE_W-1:0] rtag;
      logic              rvld, rdrt, wen;

      skc_hash #(.SET_W(SET_W), .WAY(w), .MODE(HASH)) u_rhash (
        .a1(req_a1), .a2(req_a2), .idx(ridx));
      skc_hash #(.SET_W(SET_W), .WAY(w), .MODE(HASH)) u_whash (
        .a1(fil_a1), .a2(fil_a2), .idx(widx));

      assign wen = fill_valid && (fill_way == WAY_W'(w));

      skc_way_store #(.SET_W(SET_W), .TAG_W(LINE_W)) u_store (
        .clk(clk), .rst(rst), .raddr(ridx), .we(wen), .waddr(widx),
        .wtag(fill_line), .wdirty(fill_dirty),
        .rd_tag(rtag), .rd_vld(rvld), .rd_drt(rdrt));

      always_ff @(posedge clk) begin
        if (rst) ridx_q <= '0;
        else if (req_valid) ridx_q <= ridx;
      end

      assign resp_hit_way[w] = vld_q && rvld && (rtag == tag_q);
      assign cand_valid[w] = rvld;
      assign cand_dirty[w] = rdrt;
      assign cand_tag[w*LINE_W +: LINE_W] = rtag;
      assign cand_idx[w*SET_W +: SET_W] = ridx_q;
    end
  endgenerate

  assign resp_valid = vld_q;
  assign resp_hit = |resp_hit_way;

  p_resp_follows_req_r5: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);
  p_no_spurious_resp_r5: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !resp_valid);
  p_hit_way_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $onehot0(resp_hit_way));
  p_hit_only_on_resp_r6: assert property (@(posedge clk) disable iff (rst)
    resp_hit |-> resp_valid);
endmodule

// File: tb/sim_skc_lookup.sv
module sim_skc_lookup;
  localparam int PERIOD = 10;
  localparam int SW = 4;
  localparam int NW = 8;
  localparam int LW = 23;
  localparam int NS = 1 << SW;

  typedef struct {
    bit              hit;
    bit [NW-1:0]     hw, cv, cd;
    bit [NW*LW-1:0]  ct;
    bit [NW*SW-1:0]  ci;
    string           rq;
  } exp_t;

  logic clk = 0, rst = 1;
  logic req_valid = 0, fill_valid = 0, fill_dirty = 0;
  logic [LW-1:0] req_line = '0, fill_line = '0;
  logic [2:0] fill_way = '0;

  logic rv0, rh0, rv1, rh1;
  logic [NW-1:0] hw0, cv0, cd0, hw1, cv1, cd1;
  logic [NW*LW-1:0] ct0, ct1;
  logic [NW*SW-1:0] ci0, ci1;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  exp_t q0[$], q1[$];
  bit [LW-1:0] mtag [2][NW][NS];
  bit mv [2][NW][NS];
  bit md [2][NW][NS];
  int unsigned seed = 32'h1234_5678;

  always #(PERIOD/2) clk = ~clk;

  skc_lookup #(.SET_W(SW), .WAYS(NW), .HASH(skc_pkg::HASH_ODISP)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_line(req_line),
    .fill_valid(fill_valid), .fill_line(fill_line), .fill_way(fill_way),
    .fill_dirty(fill_dirty), .resp_valid(rv0), .resp_hit(rh0),
    .resp_hit_way(hw0), .cand_valid(cv0), .cand_dirty(cd0),
    .cand_tag(ct0), .cand_idx(ci0));

  skc_lookup #(.SET_W(SW), .WAYS(NW), .HASH(skc_pkg::HASH_XOR)) u1 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_line(req_line),
    .fill_valid(fill_valid), .fill_line(fill_line), .fill_way(fill_way),
    .fill_dirty(fill_dirty), .resp_valid(rv1), .resp_hit(rh1),
    .resp_hit_way(hw1), .cand_valid(cv1), .cand_dirty(cd1),
    .cand_tag(ct1), .cand_idx(ci1));

  // R2 R3 R4: index model, A1 = line[3:0], A2 = line[7:4]
  function automatic int exp_idx(int m, int w, int line);
    int a1 = line & 15;
    int a2 = (line >> 4) & 15;
    int r;
    if (m == 0) return ((a2 << w) + a2 + a1) & 15;
    r = w % SW;
    return (((a2 << r) | (a2 >> (SW - r))) & 15) ^ a1;
  endfunction

  function automatic exp_t build(int m, int line, string rq);
    exp_t e;
    e.rq = rq;
    e.hw = '0; e.cv = '0; e.cd = '0; e.ct = '0; e.ci = '0;
    for (int w = 0; w < NW; w++) begin
      int ix = exp_idx(m, w, line);
      e.ci[w*SW +: SW] = SW'(ix);
      e.cv[w] = mv[m][w][ix];
      e.cd[w] = md[m][w][ix];
      e.ct[w*LW +: LW] = mtag[m][w][ix];
      e.hw[w] = mv[m][w][ix] && (mtag[m][w][ix] == LW'(line));
    end
    e.hit = |e.hw;
    return e;
  endfunction

  function automatic bit present(int line);
    exp_t a = build(0, line, "");
    exp_t b = build(1, line, "");
    return a.hit || b.hit;
  endfunction

  function automatic void model_fill(int line, int way, bit d);
    for (int m = 0; m < 2; m++) begin
      int ix = exp_idx(m, way, line);
      mtag[m][way][ix] = LW'(line);
      mv[m][way][ix] = 1'b1;
      md[m][way][ix] = d;
    end
  endfunction

  task automatic chk(bit ok, string rq, string what, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic compare(int m, exp_t e, logic hit, logic [NW-1:0] hw,
                         logic [NW-1:0] cv, logic [NW-1:0] cd,
                         logic [NW*LW-1:0] ct, logic [NW*SW-1:0] ci);
    string irq = (m == 0) ? "R2" : "R4";
    logic [NW*LW-1:0] msk = '0;
    for (int w = 0; w < NW; w++) if (e.cv[w]) msk[w*LW +: LW] = '1;
    chk(hit == e.hit && hw == e.hw, e.rq, $sformatf("u%0d hit/R6", m), {hit, hw}, {e.hit, e.hw});
    chk(ci == e.ci, (e.rq == "R3") ? "R3" : irq, $sformatf("u%0d cand_idx", m), ci, e.ci);
    chk(cv == e.cv && cd == e.cd, e.rq, $sformatf("u%0d cand vld/dirty R7", m), {cv, cd}, {e.cv, e.cd});
    chk((ct & msk) == (e.ct & msk), e.rq, $sformatf("u%0d cand_tag R7", m), ct & msk, e.ct & msk);
  endtask

  // monitor: samples shortly after each rising edge
  always @(posedge clk) begin
    #2;
    if (!rst && !done) begin
      chk(rv0 == (q0.size() != 0), "R5", "u0 resp_valid", rv0, q0.size() != 0);
      chk(rv1 == (q1.size() != 0), "R5", "u1 resp_valid", rv1, q1.size() != 0);
      if (q0.size() != 0) compare(0, q0.pop_front(), rh0, hw0, cv0, cd0, ct0, ci0);
      if (q1.size() != 0) compare(1, q1.pop_front(), rh1, hw1, cv1, cd1, ct1, ci1);
    end
  end

  // driver: one lookup, optionally with a fill in the same cycle
  task automatic lookup(int line, string rq, bit wf = 0, int fw = 0, bit fd = 0);
    @(negedge clk);
    q0.push_back(build(0, line, rq));
    q1.push_back(build(1, line, rq));
    req_valid = 1; req_line = LW'(line);
    if (wf) begin
      fill_valid = 1; fill_line = LW'(line); fill_way = 3'(fw); fill_dirty = fd;
      model_fill(line, fw, fd);
    end
    @(negedge clk);
    req_valid = 0; fill_valid = 0;
  endtask

  task automatic fill(int line, int fw, bit fd);
    @(negedge clk);
    fill_valid = 1; fill_line = LW'(line); fill_way = 3'(fw); fill_dirty = fd;
    model_fill(line, fw, fd);
    @(negedge clk);
    fill_valid = 0;
  endtask

  function automatic int unsigned nxt();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 7;
  endfunction

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int pool [24];
    for (int m = 0; m < 2; m++)
      for (int w = 0; w < NW; w++)
        for (int s = 0; s < NS; s++) begin
          mv[m][w][s] = 0; md[m][w][s] = 0; mtag[m][w][s] = '0;
        end
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk(rv0 == 0 && rv1 == 0, "R9", "resp_valid after reset", {rv0, rv1}, 0);
    // R9: lookups after reset miss with every candidate invalid
    lookup(23'h12345, "R9");
    lookup(23'h0, "R9");
    // R8: single fill into way 2, dirty
    fill(23'h00a53, 2, 1);
    lookup(23'h00a53, "R8");
    // R3: A1=3, A2=5 -> ways 4..7 of u0 share index 8
    lookup(23'h00053, "R3");
    // R1: same upper bits, A1/A2 differ, same way-0 index in u0
    fill(23'h7c010, 0, 0);
    lookup(23'h7c002, "R1");
    lookup(23'h7c010, "R1");
    // R10: lookup with simultaneous fill sees old contents
    begin
      int ln = 23'h3f1e7;
      @(negedge clk);
      q0.push_back(build(0, ln, "R10"));
      q1.push_back(build(1, ln, "R10"));
      req_valid = 1; req_line = LW'(ln);
      fill_valid = 1; fill_line = LW'(ln); fill_way = 3'd5; fill_dirty = 1;
      model_fill(ln, 5, 1);
      @(negedge clk);
      req_valid = 0; fill_valid = 0;
      lookup(ln, "R10");
    end
    // R6 R7 R8: pool of lines, fill on miss, then look again
    for (int i = 0; i < 24; i++) pool[i] = int'(nxt() & 23'h7fffff);
    for (int i = 0; i < 120; i++) begin
      int ln = pool[nxt() % 24];
      lookup(ln, "R6");
      if (!present(ln)) begin
        fill(ln, int'(nxt() % NW), bit'(nxt() & 1));
        lookup(ln, "R8");
      end
    end
    // R5: back-to-back requests
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      q0.push_back(build(0, pool[i], "R5"));
      q1.push_back(build(1, pool[i], "R5"));
      req_valid = 1; req_line = LW'(pool[i]);
      @(negedge clk);
    end
    req_valid = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule